// File: doc/BRIEF.md
# Fly-by DMA Endpoint Port

This block is the peripheral half of a fly-by DMA handshake inside a USB device controller with fourteen endpoint buffers. Software writes a DMA target register that holds a 4-bit endpoint code and an enable bit. A separate hardware-configuration bit picks between the full request/acknowledge handshake and an acknowledge-only mode. When the chosen endpoint can move a word, the block raises a request. The external DMA controller answers with an acknowledge and one read or write strobe per word. The data word passes straight between the bus and the endpoint FIFO port on that strobe, and nothing is stored inside the block.

While acknowledge is active, every strobe goes to the DMA target endpoint, whatever endpoint the processor has selected for programmed I/O. The direction bit of the target endpoint decides which strobe is legal. An end-of-transfer input stops the request, and the request stays down until software arms the port again. A strobe that cannot be served is dropped and raises a sticky error flag.

All routing outputs are combinational from the strobes and the stored configuration. Only the configuration, the armed state and the error flag are registered.

Top module: `flyby_dma_port`

## Requirements
- R1: A DMA target code k from 2 to 15 addresses endpoint k-1. Its FIFO port is bit k-2 of `epPop`, `epPush`, `epDir`, `epHasData` and `epHasSpace`, and slice k-2 of `epRdData`.
- R2: Under acknowledge, a target with direction bit 0 accepts only a lone read strobe. That strobe pops the endpoint and places its head word on `dataOut` in the same cycle. A target with direction bit 1 accepts only a lone write strobe, which pushes `dataIn` through `epWrData` in the same cycle.
- R3: While `dack` is high, strobes reach the DMA target and ignore `pioCs` and `pioEpIdx`. While `dack` is low, a lone strobe with `pioCs` high and `pioEpIdx` from 2 to 15 pops or pushes that endpoint, and no direction check is made.
- R4: `dreq` is high exactly when all of these hold in the same cycle: the port is armed, acknowledge-only mode is off, the target code is at least 2, `eot` is low, and the target is ready. A target with direction bit 0 is ready when its data flag is set. A target with direction bit 1 is ready when its space flag is set.
- R5: With the acknowledge-only bit set, `dreq` stays low. Acknowledged strobes still move data as in R2.
- R6: `eot` forces `dreq` low in its own cycle and disarms the port. A strobe in the same cycle as `eot` still transfers. The port re-arms only through a configuration write whose enable bit is 1. If that write falls in the same cycle as `eot`, `eot` wins.
- R7: An acknowledged strobe is illegal when the target code is 0 or 1, or when the strobe does not match the direction. An illegal strobe moves nothing and sets `dmaErr` from the next cycle on. `dmaErr` stays set until a configuration write clears it. An illegal strobe in the same cycle as that write leaves `dmaErr` set.
- R8: `dataOe` is high only during a read strobe that pops an endpoint under R2 or R3. In every other cycle `dataOe` is low and `dataOut` is zero.
- R9: Read and write strobes that are both high move nothing. Under acknowledge this counts as illegal. At most one bit of `epPop` and `epPush` together is ever set.
- R10: After reset, the port is disarmed, the target code is 0, acknowledge-only mode is off, and `dreq` and `dmaErr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Write the DMA target register |
| cfgEpIdx | input | 4 | Endpoint code written to the target register |
| cfgDmaEn | input | 1 | Enable bit written with the target register (1 arms the port) |
| hwCfgWe | input | 1 | Write the acknowledge-only bit |
| hwAckOnly | input | 1 | Acknowledge-only value (0 means full handshake) |
| epDir | input | 14 | Per-endpoint direction bit (1 = IN) |
| epHasData | input | 14 | Per-endpoint FIFO not empty |
| epHasSpace | input | 14 | Per-endpoint FIFO not full |
| epRdData | input | 224 | Per-endpoint FIFO head words, 16 bits each |
| epPop | output | 14 | Per-endpoint pop strobe |
| epPush | output | 14 | Per-endpoint push strobe |
| epWrData | output | 16 | Word offered to endpoint FIFOs |
| pioCs | input | 1 | Processor chip select for programmed I/O |
| pioEpIdx | input | 4 | Endpoint code used for programmed I/O |
| dack | input | 1 | DMA acknowledge |
| rdStb | input | 1 | Read strobe (one word per high cycle) |
| wrStb | input | 1 | Write strobe (one word per high cycle) |
| eot | input | 1 | End of transfer |
| dataIn | input | 16 | Bus word for writes |
| dataOut | output | 16 | Bus word for reads |
| dataOe | output | 1 | Bus drive enable (bus is released when low) |
| dreq | output | 1 | DMA request |
| dmaErr | output | 1 | Sticky illegal-strobe flag |

## Verification
Two pairs of events can land in the same clock edge. The first pair is end-of-transfer and a data strobe. The second is an illegal strobe and a configuration write, which both try to change the error flag. The bench drives each pair together on purpose, in directed steps and in the random phase, where `eot`, the strobes and the configuration writes are drawn independently. A correct result has three parts. The word still moves in the `eot` cycle and the request falls in that same cycle. The port stays disarmed even when an arming write lands with `eot`. The error flag stays set when the clearing write collides with a new illegal strobe.

// File: rtl/flyby_dma_pkg.sv
package flyby_dma_pkg;
  // Strobes from control to datapath for one bus cycle.
  typedef struct packed {
    logic useDma;    // target is the DMA register, not the PIO index
    logic popGo;     // pop the target endpoint
    logic pushGo;    // push into the target endpoint
    logic driveBus;  // enable the bus output
  } xferCtl_t;
endpackage

// File: rtl/flyby_dma_ctrl.sv
module flyby_dma_ctrl
  import flyby_dma_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int EP_BASE = 2,
  parameter int NUM_EP  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgEpIdx,
  input  logic              cfgDmaEn,
  input  logic              hwCfgWe,
  input  logic              hwAckOnly,
  input  logic [NUM_EP-1:0] epDir,
  input  logic [NUM_EP-1:0] epHasData,
  input  logic [NUM_EP-1:0] epHasSpace,
  input  logic              pioCs,
  input  logic [IDX_W-1:0]  pioEpIdx,
  input  logic              dack,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              eot,
  output logic [IDX_W-1:0]  dmaIdx,
  output xferCtl_t          ctl,
  output logic              dreq,
  output logic              dmaErr
);
  localparam int LAST_CODE = EP_BASE + NUM_EP - 1;

  logic ackOnly;
  logic armed;
  logic selDir, selData, selSpace;
  logic dmaIdxOk, pioIdxOk;
  logic rdOnly, wrOnly;
  logic dmaRdOk, dmaWrOk, dmaBad;

  // Status of the DMA target endpoint.
  always_comb begin
    selDir   = 1'b0;
    selData  = 1'b0;
    selSpace = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (dmaIdx == IDX_W'(i + EP_BASE)) begin
        selDir   = epDir[i];
        selData  = epHasData[i];
        selSpace = epHasSpace[i];
      end
    end
  end

  assign dmaIdxOk = (int'(dmaIdx) >= EP_BASE) && (int'(dmaIdx) <= LAST_CODE);
  assign pioIdxOk = (int'(pioEpIdx) >= EP_BASE) && (int'(pioEpIdx) <= LAST_CODE);

  assign rdOnly  = rdStb && !wrStb;
  assign wrOnly  = wrStb && !rdStb;
  assign dmaRdOk = dmaIdxOk && !selDir && rdOnly;
  assign dmaWrOk = dmaIdxOk &&  selDir && wrOnly;
  assign dmaBad  = dack && (rdStb || wrStb) && !(dmaRdOk || dmaWrOk);

  // Acknowledge overrides the programmed-I/O selection.
  always_comb begin
    ctl.useDma = dack;
    if (dack) begin
      ctl.popGo    = dmaRdOk;
      ctl.pushGo   = dmaWrOk;
      ctl.driveBus = dmaRdOk;
    end else begin
      ctl.popGo    = pioCs && pioIdxOk && rdOnly;
      ctl.pushGo   = pioCs && pioIdxOk && wrOnly;
      ctl.driveBus = pioCs && pioIdxOk && rdOnly;
    end
  end

  assign dreq = armed && !ackOnly && dmaIdxOk && !eot &&
                (selDir ? selSpace : selData);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaIdx  <= '0;
      armed   <= 1'b0;
      ackOnly <= 1'b0;
      dmaErr  <= 1'b0;
    end else begin
      if (cfgWe) dmaIdx <= cfgEpIdx;
      if (hwCfgWe) ackOnly <= hwAckOnly;
      if (eot) armed <= 1'b0;
      else if (cfgWe) armed <= cfgDmaEn;
      if (dmaBad) dmaErr <= 1'b1;
      else if (cfgWe) dmaErr <= 1'b0;
    end
  end
endmodule

// File: rtl/flyby_dma_dpath.sv
module flyby_dma_dpath
  import flyby_dma_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int EP_BASE = 2,
  parameter int NUM_EP  = 14,
  parameter int DATA_W  = 16
) (
  input  xferCtl_t                 ctl,
  input  logic [IDX_W-1:0]         dmaIdx,
  input  logic [IDX_W-1:0]         pioEpIdx,
  input  logic [NUM_EP*DATA_W-1:0] epRdData,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [NUM_EP-1:0]        epPop,
  output logic [NUM_EP-1:0]        epPush,
  output logic [DATA_W-1:0]        epWrData,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe
);
  logic [IDX_W-1:0]  tgtIdx;
  logic [NUM_EP-1:0] tgtHit;
  logic [DATA_W-1:0] headWord [NUM_EP];
  logic [DATA_W-1:0] muxWord;

  assign tgtIdx = ctl.useDma ? dmaIdx : pioEpIdx;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
    assign tgtHit[g]   = (tgtIdx == IDX_W'(g + EP_BASE));
    assign epPop[g]    = ctl.popGo  && tgtHit[g];
    assign epPush[g]   = ctl.pushGo && tgtHit[g];
    assign headWord[g] = epRdData[g*DATA_W +: DATA_W];
  end

  always_comb begin
    muxWord = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (tgtHit[i]) muxWord = headWord[i];
    end
  end

  // Fly-by: the bus word goes straight to the FIFO write port.
  assign epWrData = dataIn;
  assign dataOe   = ctl.driveBus;
  assign dataOut  = ctl.driveBus ? muxWord : '0;
endmodule

// File: rtl/flyby_dma_port.sv
module flyby_dma_port
  import flyby_dma_pkg::*;
#(
  parameter int IDX_W   = 4,
  parameter int EP_BASE = 2,
  parameter int NUM_EP  = 14,
  parameter int DATA_W  = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [IDX_W-1:0]         cfgEpIdx,
  input  logic                     cfgDmaEn,
  input  logic                     hwCfgWe,
  input  logic                     hwAckOnly,
  input  logic [NUM_EP-1:0]        epDir,
  input  logic [NUM_EP-1:0]        epHasData,
  input  logic [NUM_EP-1:0]        epHasSpace,
  input  logic [NUM_EP*DATA_W-1:0] epRdData,
  output logic [NUM_EP-1:0]        epPop,
  output logic [NUM_EP-1:0]        epPush,
  output logic [DATA_W-1:0]        epWrData,
  input  logic                     pioCs,
  input  logic [IDX_W-1:0]         pioEpIdx,
  input  logic                     dack,
  input  logic                     rdStb,
  input  logic                     wrStb,
  input  logic                     eot,
  input  logic [DATA_W-1:0]        dataIn,
  output logic [DATA_W-1:0]        dataOut,
  output logic                     dataOe,
  output logic                     dreq,
  output logic                     dmaErr
);
  xferCtl_t         ctl;
  logic [IDX_W-1:0] dmaIdx;

  flyby_dma_ctrl #(
    .IDX_W(IDX_W), .EP_BASE(EP_BASE), .NUM_EP(NUM_EP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgEpIdx(cfgEpIdx), .cfgDmaEn(cfgDmaEn),
    .hwCfgWe(hwCfgWe), .hwAckOnly(hwAckOnly),
    .epDir(epDir), .epHasData(epHasData), .epHasSpace(epHasSpace),
    .pioCs(pioCs), .pioEpIdx(pioEpIdx),
    .dack(dack), .rdStb(rdStb), .wrStb(wrStb), .eot(eot),
    .dmaIdx(dmaIdx), .ctl(ctl), .dreq(dreq), .dmaErr(dmaErr)
  );

  flyby_dma_dpath #(
    .IDX_W(IDX_W), .EP_BASE(EP_BASE), .NUM_EP(NUM_EP), .DATA_W(DATA_W)
  ) u_dpath (
    .ctl(ctl), .dmaIdx(dmaIdx), .pioEpIdx(pioEpIdx),
    .epRdData(epRdData), .dataIn(dataIn),
    .epPop(epPop), .epPush(epPush), .epWrData(epWrData),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/flyby_dma_checks.sv
module flyby_dma_checks #(
  parameter int NUM_EP = 14
) (
  input logic              clk,
  input logic              rstN,
  input logic              cfgWe,
  input logic              dack,
  input logic              pioCs,
  input logic              rdStb,
  input logic              wrStb,
  input logic              eot,
  input logic [NUM_EP-1:0] epPop,
  input logic [NUM_EP-1:0] epPush,
  input logic              dataOe,
  input logic              dreq,
  input logic              dmaErr
);
  assert_single_move_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({epPop, epPush}));

  assert_pop_needs_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|epPop) |-> (rdStb && !wrStb));

  assert_push_needs_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|epPush) |-> (wrStb && !rdStb));

  assert_eot_drops_dreq_R6: assert property (@(posedge clk) disable iff (!rstN)
    eot |-> !dreq);

  assert_eot_disarms_R6: assert property (@(posedge clk) disable iff (!rstN)
    eot |=> !dreq);

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dmaErr && !cfgWe) |=> dmaErr);

  assert_oe_only_read_R8: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (rdStb && (dack || pioCs)));
endmodule

bind flyby_dma_port flyby_dma_checks #(.NUM_EP(NUM_EP)) u_checks (
  .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .dack(dack), .pioCs(pioCs),
  .rdStb(rdStb), .wrStb(wrStb), .eot(eot), .epPop(epPop), .epPush(epPush),
  .dataOe(dataOe), .dreq(dreq), .dmaErr(dmaErr)
);

// File: tb/test_flyby_dma_port.sv
module test_flyby_dma_port;
  localparam int NE = 14;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 0, cfgDmaEn = 0, hwCfgWe = 0, hwAckOnly = 0;
  logic [3:0] cfgEpIdx = '0, pioEpIdx = '0;
  logic [NE-1:0] epDir = '0, epHasData = '0, epHasSpace = '0;
  logic [NE*DW-1:0] epRdData = '0;
  logic pioCs = 0, dack = 0, rdStb = 0, wrStb = 0, eot = 0;
  logic [DW-1:0] dataIn = '0;
  logic [NE-1:0] epPop, epPush;
  logic [DW-1:0] epWrData, dataOut;
  logic dataOe, dreq, dmaErr;

  int errors = 0;
  int checks = 0;
  logic [3:0] mIdx;
  logic mArmed, mAck, mErr;

  always #4 clk = ~clk;

  flyby_dma_port i_flyby_dma_port (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgEpIdx(cfgEpIdx),
    .cfgDmaEn(cfgDmaEn), .hwCfgWe(hwCfgWe), .hwAckOnly(hwAckOnly),
    .epDir(epDir), .epHasData(epHasData), .epHasSpace(epHasSpace),
    .epRdData(epRdData), .epPop(epPop), .epPush(epPush), .epWrData(epWrData),
    .pioCs(pioCs), .pioEpIdx(pioEpIdx), .dack(dack), .rdStb(rdStb),
    .wrStb(wrStb), .eot(eot), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .dreq(dreq), .dmaErr(dmaErr)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] headOf(int e);
    return epRdData[e*DW +: DW];
  endfunction

  // One cycle: inputs are already set after a falling edge; predict, compare,
  // then advance the model through the next rising edge.
  task automatic step(string req);
    logic rdO, wrO, ok, pOk, legRd, legWr, bad, expDreq;
    logic [3:0] tgt;
    logic [NE-1:0] expPop, expPush;
    logic [DW-1:0] expOut;
    int di;
    #2;
    rdO = rdStb && !wrStb;
    wrO = wrStb && !rdStb;
    ok  = (mIdx >= 4'd2);
    pOk = (pioEpIdx >= 4'd2);
    di  = ok ? int'(mIdx) - 2 : 0;
    if (dack) begin
      legRd = ok && !epDir[di] && rdO;
      legWr = ok &&  epDir[di] && wrO;
      tgt = mIdx;
    end else begin
      legRd = pioCs && pOk && rdO;
      legWr = pioCs && pOk && wrO;
      tgt = pioEpIdx;
    end
    bad = dack && (rdStb || wrStb) && !(legRd || legWr);
    expPop  = legRd ? NE'(1) << (int'(tgt) - 2) : '0;
    expPush = legWr ? NE'(1) << (int'(tgt) - 2) : '0;
    expOut  = legRd ? headOf(int'(tgt) - 2) : '0;
    expDreq = mArmed && !mAck && ok && !eot &&
              (epDir[di] ? epHasSpace[di] : epHasData[di]);
    chk(req, "epPop", 64'(epPop), 64'(expPop));
    chk(req, "epPush", 64'(epPush), 64'(expPush));
    chk(req, "dataOe", 64'(dataOe), 64'(legRd));
    chk(req, "dataOut", 64'(dataOut), 64'(expOut));
    chk(req, "epWrData", 64'(epWrData), 64'(dataIn));
    chk(req, "dreq", 64'(dreq), 64'(expDreq));
    chk(req, "dmaErr", 64'(dmaErr), 64'(mErr));
    if (bad) mErr = 1'b1;
    else if (cfgWe) mErr = 1'b0;
    if (eot) mArmed = 1'b0;
    else if (cfgWe) mArmed = cfgDmaEn;
    if (cfgWe) mIdx = cfgEpIdx;
    if (hwCfgWe) mAck = hwAckOnly;
    @(negedge clk);
  endtask

  task automatic idle();
    cfgWe = 0; hwCfgWe = 0; pioCs = 0; dack = 0; rdStb = 0; wrStb = 0; eot = 0;
  endtask

  task automatic arm(logic [3:0] code);
    idle(); cfgWe = 1; cfgEpIdx = code; cfgDmaEn = 1;
    step("R6");
    idle();
  endtask

  task automatic fillHeads();
    for (int e = 0; e < NE; e++) epRdData[e*DW +: DW] = DW'($urandom);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mIdx = '0; mArmed = 0; mAck = 0; mErr = 0;
    repeat (3) @(negedge clk);
    chk("R10", "dreq", 64'(dreq), 64'd0);
    chk("R10", "dmaErr", 64'(dmaErr), 64'd0);
    chk("R10", "epPop", 64'(epPop), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    fillHeads();
    epHasData = '1; epHasSpace = '1;
    step("R10");

    // R1: every code maps to its own endpoint slot, read and write.
    for (int k = 2; k < 16; k++) begin
      arm(4'(k));
      epDir = '0; dack = 1; rdStb = 1; fillHeads();
      step("R1");
      idle(); epDir = '1; dack = 1; wrStb = 1; dataIn = DW'($urandom);
      step("R1");
      idle();
    end

    // R3: acknowledge overrides PIO select; PIO path when no acknowledge.
    arm(4'd5); epDir = '0;
    dack = 1; pioCs = 1; pioEpIdx = 4'd9; rdStb = 1;
    step("R3");
    dack = 0;
    step("R3");
    rdStb = 0; wrStb = 1; epDir = '0;
    step("R3");
    idle();

    // R4 / R5: readiness and acknowledge-only mode.
    epDir = '0; epHasData = '0;
    step("R4");
    epHasData = '1;
    step("R4");
    hwCfgWe = 1; hwAckOnly = 1;
    step("R5");
    idle(); dack = 1; rdStb = 1;
    step("R5");
    idle(); hwCfgWe = 1; hwAckOnly = 0;
    step("R5");
    idle();

    // R6: eot with a strobe, then hold, then eot colliding with an arming write.
    dack = 1; rdStb = 1; eot = 1;
    step("R6");
    idle();
    step("R6");
    step("R6");
    cfgWe = 1; cfgEpIdx = 4'd5; cfgDmaEn = 1; eot = 1;
    step("R6");
    idle();
    step("R6");
    arm(4'd5);
    step("R6");

    // R7 / R9: illegal strobes, sticky error, clear colliding with new error.
    dack = 1; wrStb = 1;
    step("R7");
    idle();
    step("R7");
    dack = 1; rdStb = 1; cfgWe = 1; cfgEpIdx = 4'd5; cfgDmaEn = 1; wrStb = 1;
    step("R9");
    idle();
    step("R7");
    cfgWe = 1; cfgEpIdx = 4'd1; cfgDmaEn = 1;
    step("R7");
    idle(); dack = 1; rdStb = 1;
    step("R7");
    idle();
    step("R8");

    // Random phase.
    for (int n = 0; n < 3000; n++) begin
      fillHeads();
      epDir      = NE'($urandom);
      epHasData  = NE'($urandom);
      epHasSpace = NE'($urandom);
      dack  = ($urandom % 2) == 0;
      rdStb = ($urandom % 5) < 2;
      wrStb = ($urandom % 5) < 2;
      pioCs = ($urandom % 2) == 0;
      pioEpIdx = 4'($urandom);
      eot   = ($urandom % 20) == 0;
      cfgWe = ($urandom % 16) == 0;
      cfgEpIdx = 4'($urandom);
      cfgDmaEn = ($urandom % 4) != 0;
      hwCfgWe = ($urandom % 30) == 0;
      hwAckOnly = ($urandom % 3) == 0;
      dataIn = DW'($urandom);
      step("R4");
    end
    idle();
    step("R8");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule